// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Collector

The block gathers a set of interrupt request wires and presents them to several processor cores. Each core receives a small group of parent interrupt lines. Every request wire first passes through a two-stage synchroniser. It is then qualified by a per-source polarity bit, and it is either passed through as a level or captured as an edge. An enable mask gates each source. A per-source routing byte then steers the result onto any parent line of any core. Each parent output is the registered OR of every enabled, pending source that is routed to it.

Software reaches the block over a simple register bus. The bus takes byte writes into the routing area and word writes and word reads everywhere else. Enables are changed through a write-1-to-set word and a write-1-to-clear word, so one source can be masked without a read-modify-write. A masked-pending status word lists the active sources. Software services that word from its lowest set bit upward, and writing ones to it discards captured edges.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the enable word (0x24), the edge-select word (0x34), all routing bytes and the status word (0x40) read zero, the polarity word (0x30) reads all ones, and every parent output is low.
- R2: A byte write at offsets 0x00..0x1F replaces the routing byte of the source with that number. A word write at an aligned offset in that range replaces four routing bytes, with the lowest source in bits [7:0]. A word read there returns the routing bytes in the same layout.
- R3: A word write at 0x28 enables every source whose data bit is 1 and leaves sources with a 0 bit unchanged.
- R4: A word write at 0x2C disables every source whose data bit is 1 and leaves sources with a 0 bit unchanged. All ones masks every source in one access.
- R5: The word at 0x24 reads back the current enable mask. The words at 0x30 (1 = active-high or rising, 0 = active-low or falling) and 0x34 (1 = edge, 0 = level) are plain read/write words.
- R6: In level mode a source is pending while its synchronised input equals its polarity bit. An input change appears on the parent output at the third rising clock edge after the change.
- R7: In edge mode a source becomes pending on the selected transition of its synchronised input and stays pending after the input returns. Writing a 1 to its bit at 0x40 clears it, and 0 bits have no effect.
- R8: The word at 0x40 reads the pending sources ANDed with the enable mask.
- R9: Parent output bit c*4+l is high one clock after some enabled pending source has routing-byte bit 4+l (line l) and bit c (core c) both set. A source whose routing byte is zero drives no output.
- R10: Word reads of unmapped offsets (including 0x20, 0x28, 0x2C and 0x38) return zero. Word writes to unmapped offsets, and byte writes outside 0x00..0x1F, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Asynchronous interrupt request wires, one per source |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_word | input | 1 | 1 = word access at the aligned address, 0 = byte access |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data; byte writes use bits [7:0] |
| bus_rdata | output | 32 | Combinational word read data for bus_addr |
| irq_out | output | 16 | Parent lines, bit index core*4+line |

## Verification
The assertions assume that writes arrive as single-cycle strobes whose address and data are stable at the clock edge. They also assume that the enable words are always written as whole aligned words. The bench drives every bus signal and every request wire on the falling clock edge and holds each write for exactly one cycle. It waits five cycles after each change to a request wire before sampling, so the synchroniser and output register have settled. Request wires change only while the affected source's mode is fixed, so no edge is created or lost by a mode change.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    // Fields that software and the fan-out stage both decode.
    localparam int ROUTE_W      = 8;
    localparam int LINE_LSB     = 4;
    localparam int WORD_W       = 32;

    // Word-aligned control offsets.
    localparam logic [7:0] OFS_EN_STATE = 8'h24;
    localparam logic [7:0] OFS_EN_SET   = 8'h28;
    localparam logic [7:0] OFS_EN_CLR   = 8'h2C;
    localparam logic [7:0] OFS_POL      = 8'h30;
    localparam logic [7:0] OFS_EDGE     = 8'h34;
    localparam logic [7:0] OFS_STAT     = 8'h40;
endpackage

// File: rtl/irqr_cond.sv
module irqr_cond #(
    parameter int SRC_N       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] raw_in,
    input  logic [SRC_N-1:0] pol,
    input  logic [SRC_N-1:0] edge_mode,
    input  logic [SRC_N-1:0] edge_clr,
    output logic [SRC_N-1:0] pending
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][SRC_N-1:0] sync;
        logic [SRC_N-1:0]                  prev;
        logic [SRC_N-1:0]                  latch;
    } cond_t;

    cond_t            st_d, st_q;
    logic [SRC_N-1:0] act_now;
    logic [SRC_N-1:0] act_old;
    logic [SRC_N-1:0] fresh;

    // Qualified activity: input equal to polarity bit means active.
    assign act_now = ~(st_q.sync[LAST] ^ pol);
    assign act_old = ~(st_q.prev ^ pol);
    assign fresh   = act_now & ~act_old;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = raw_in;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev  = st_q.sync[LAST];
        // A new edge wins over a clear arriving in the same cycle.
        st_d.latch = edge_mode & (fresh | (st_q.latch & ~edge_clr));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = (edge_mode & st_q.latch) | (~edge_mode & act_now);
endmodule

// File: rtl/irqr_regs.sv
module irqr_regs
    import irqr_pkg::*;
#(
    parameter int SRC_N  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic                     bus_word,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    input  logic [SRC_N-1:0]         status,
    output logic [SRC_N-1:0]         en_mask,
    output logic [SRC_N-1:0]         pol,
    output logic [SRC_N-1:0]         edge_mode,
    output logic [SRC_N-1:0]         edge_clr,
    output logic [SRC_N*ROUTE_W-1:0] route,
    output logic [WORD_W-1:0]        rdata
);
    localparam int BYTES_PER_WORD = WORD_W / 8;

    typedef struct packed {
        logic [SRC_N-1:0]              en;
        logic [SRC_N-1:0]              pol;
        logic [SRC_N-1:0]              edge_sel;
        logic [SRC_N-1:0][ROUTE_W-1:0] route;
    } regs_t;

    regs_t             st_d, st_q;
    logic [ADDR_W-1:0] word_addr;
    logic              wr_word;
    logic              wr_byte;

    assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
    assign wr_word   = bus_we & bus_word;
    assign wr_byte   = bus_we & ~bus_word;

    always_comb begin
        st_d     = st_q;
        edge_clr = '0;
        // Routing area: byte or word writes.
        for (int b = 0; b < SRC_N; b++) begin
            if (wr_byte && bus_addr == ADDR_W'(b)) begin
                st_d.route[b] = bus_wdata[7:0];
            end
            if (wr_word && word_addr == ADDR_W'(b - (b % BYTES_PER_WORD))) begin
                st_d.route[b] = bus_wdata[8*(b % BYTES_PER_WORD) +: 8];
            end
        end
        // Control words: word writes only.
        if (wr_word) begin
            case (word_addr)
                ADDR_W'(OFS_EN_SET): st_d.en       = st_q.en | bus_wdata[SRC_N-1:0];
                ADDR_W'(OFS_EN_CLR): st_d.en       = st_q.en & ~bus_wdata[SRC_N-1:0];
                ADDR_W'(OFS_POL):    st_d.pol      = bus_wdata[SRC_N-1:0];
                ADDR_W'(OFS_EDGE):   st_d.edge_sel = bus_wdata[SRC_N-1:0];
                ADDR_W'(OFS_STAT):   edge_clr      = bus_wdata[SRC_N-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (word_addr)
            ADDR_W'(OFS_EN_STATE): rdata[SRC_N-1:0] = st_q.en;
            ADDR_W'(OFS_POL):      rdata[SRC_N-1:0] = st_q.pol;
            ADDR_W'(OFS_EDGE):     rdata[SRC_N-1:0] = st_q.edge_sel;
            ADDR_W'(OFS_STAT):     rdata[SRC_N-1:0] = status;
            default: ;
        endcase
        for (int b = 0; b < SRC_N; b++) begin
            if (word_addr == ADDR_W'(b - (b % BYTES_PER_WORD))) begin
                rdata[8*(b % BYTES_PER_WORD) +: 8] = st_q.route[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en       <= '0;
            st_q.pol      <= '1;
            st_q.edge_sel <= '0;
            st_q.route    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_mask   = st_q.en;
    assign pol       = st_q.pol;
    assign edge_mode = st_q.edge_sel;
    assign route     = st_q.route;
endmodule

// File: rtl/irqr_fanout.sv
module irqr_fanout
    import irqr_pkg::*;
#(
    parameter int SRC_N  = 32,
    parameter int LINE_N = 4,
    parameter int CORE_N = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SRC_N-1:0]           status,
    input  logic [SRC_N*ROUTE_W-1:0]   route,
    output logic [CORE_N*LINE_N-1:0]   irq_out
);
    localparam int OUT_N = CORE_N * LINE_N;

    typedef struct packed {
        logic [OUT_N-1:0] lines;
    } fan_t;

    fan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < CORE_N; c++) begin
            for (int l = 0; l < LINE_N; l++) begin
                logic acc;
                acc = 1'b0;
                for (int s = 0; s < SRC_N; s++) begin
                    acc = acc | (status[s]
                                 & route[s*ROUTE_W + LINE_LSB + l]
                                 & route[s*ROUTE_W + c]);
                end
                st_d.lines[c*LINE_N + l] = acc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out = st_q.lines;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irqr_pkg::*;
#(
    parameter int SRC_N       = 32,
    parameter int LINE_N      = 4,
    parameter int CORE_N      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SRC_N-1:0]         irq_in,
    input  logic                     bus_we,
    input  logic                     bus_word,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    output logic [CORE_N*LINE_N-1:0] irq_out
);
    logic [SRC_N-1:0]         en_mask;
    logic [SRC_N-1:0]         pol_vec;
    logic [SRC_N-1:0]         edge_vec;
    logic [SRC_N-1:0]         clr_vec;
    logic [SRC_N-1:0]         pend_vec;
    logic [SRC_N-1:0]         status_vec;
    logic [SRC_N*ROUTE_W-1:0] route_vec;

    irqr_cond #(.SRC_N(SRC_N), .SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (irq_in),
        .pol       (pol_vec),
        .edge_mode (edge_vec),
        .edge_clr  (clr_vec),
        .pending   (pend_vec)
    );

    assign status_vec = pend_vec & en_mask;

    irqr_regs #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status_vec),
        .en_mask   (en_mask),
        .pol       (pol_vec),
        .edge_mode (edge_vec),
        .edge_clr  (clr_vec),
        .route     (route_vec),
        .rdata     (bus_rdata)
    );

    irqr_fanout #(.SRC_N(SRC_N), .LINE_N(LINE_N), .CORE_N(CORE_N)) u_fan (
        .clk     (clk),
        .rst_n   (rst_n),
        .status  (status_vec),
        .route   (route_vec),
        .irq_out (irq_out)
    );
endmodule

// File: rtl/irqr_chk.sv
module irqr_chk
    import irqr_pkg::*;
#(
    parameter int SRC_N  = 32,
    parameter int OUT_N  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_word,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [SRC_N-1:0]  en_mask,
    input logic [SRC_N-1:0]  status,
    input logic [OUT_N-1:0]  irq_out
);
    logic [ADDR_W-1:0] waddr;
    logic              wword;
    assign waddr = {bus_addr[ADDR_W-1:2], 2'b00};
    assign wword = bus_we & bus_word;

    a_r3_set_bits_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wword && waddr == ADDR_W'(OFS_EN_SET))
        |=> ((en_mask & $past(bus_wdata[SRC_N-1:0])) == $past(bus_wdata[SRC_N-1:0])));

    a_r4_clear_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wword && waddr == ADDR_W'(OFS_EN_CLR))
        |=> ((en_mask & $past(bus_wdata[SRC_N-1:0])) == '0));

    a_r10_hole_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wword && waddr == ADDR_W'(8'h38)) |=> $stable(en_mask));

    a_r9_out_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> $past(|status));

    a_r9_idle_goes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|status) |=> !(|irq_out));
endmodule

bind irq_route_ctrl irqr_chk #(
    .SRC_N  (SRC_N),
    .OUT_N  (CORE_N*LINE_N),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_mask   (en_mask),
    .status    (status_vec),
    .irq_out   (irq_out)
);

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;

    int n_run = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_route_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic int line_of(int s); return s % 4; endfunction
    function automatic int core_of(int s); return (s / 4) % 4; endfunction
    function automatic logic [7:0] rbyte(int s);
        return 8'((1 << (4 + line_of(s))) | (1 << core_of(s)));
    endfunction
    function automatic logic [15:0] obit(int s);
        return 16'(1 << (core_of(s) * 4 + line_of(s)));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic word, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_word = 1'b1;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_word = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1: reset state
        chk("R1 irq_out", 32'(irq_out), 0);
        rd(8'h24, v); chk("R1 enable", v, 0);
        rd(8'h30, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
        rd(8'h34, v); chk("R1 edge", v, 0);
        rd(8'h40, v); chk("R1 status", v, 0);
        for (int a = 0; a < 32; a += 4) begin
            rd(8'(a), v); chk("R1 route", v, 0);
        end

        // R2: byte writes for sources 0..27, one word write for 28..31
        for (int s = 0; s < 28; s++) wr(1'b0, 8'(s), {24'hABCDEF, rbyte(s)});
        wr(1'b1, 8'h1C, {rbyte(31), rbyte(30), rbyte(29), rbyte(28)});
        for (int a = 0; a < 32; a += 4) begin
            w = {rbyte(a+3), rbyte(a+2), rbyte(a+1), rbyte(a)};
            rd(8'(a), v); chk("R2 route readback", v, w);
        end

        // R3: set enables in two halves
        wr(1'b1, 8'h28, 32'h0000_FFFF);
        wr(1'b1, 8'h28, 32'hFFFF_0000);
        rd(8'h24, v); chk("R3 set halves", v, 32'hFFFF_FFFF);
        // R4: clear one nibble
        wr(1'b1, 8'h2C, 32'h0000_00F0);
        rd(8'h24, v); chk("R4 clear nibble", v, 32'hFFFF_FF0F);
        wr(1'b1, 8'h28, 32'h0000_00F0);
        rd(8'h24, v); chk("R5 enable readback", v, 32'hFFFF_FFFF);

        // R6 R8 R9: level sweep over every source
        for (int s = 0; s < 32; s++) begin
            irq_in = 32'(1) << s;
            settle(5);
            rd(8'h40, v); chk("R8 status level", v, 32'(1) << s);
            chk("R9 out level", 32'(irq_out), 32'(obit(s)));
        end
        irq_in = '0;
        settle(5);
        chk("R6 out drops", 32'(irq_out), 0);

        // R6: exact latency of level path (third edge)
        @(negedge clk); irq_in = 32'h2;
        @(negedge clk); @(negedge clk);
        chk("R6 not yet", 32'(irq_out), 0);
        @(negedge clk);
        chk("R6 third edge", 32'(irq_out), 32'(obit(1)));
        irq_in = '0;
        settle(5);

        // R5 R6: active-low source 0
        wr(1'b1, 8'h30, 32'hFFFF_FFFE);
        rd(8'h30, v); chk("R5 polarity rw", v, 32'hFFFF_FFFE);
        settle(5);
        rd(8'h40, v); chk("R6 active low idle", v, 32'h1);
        chk("R6 active low out", 32'(irq_out), 32'(obit(0)));
        irq_in = 32'h1;
        settle(5);
        rd(8'h40, v); chk("R6 active low driven", v, 0);
        irq_in = '0;
        wr(1'b1, 8'h30, 32'hFFFF_FFFF);
        settle(5);

        // R8: masked source stays out of status
        wr(1'b1, 8'h2C, 32'h20);
        irq_in = 32'h20;
        settle(5);
        rd(8'h40, v); chk("R8 masked status", v, 0);
        chk("R8 masked out", 32'(irq_out), 0);
        wr(1'b1, 8'h28, 32'h20);
        settle(1);
        chk("R3 reenable out", 32'(irq_out), 32'(obit(5)));
        irq_in = '0;
        settle(5);

        // R7: rising edge capture on source 3
        wr(1'b1, 8'h34, 32'h8);
        rd(8'h34, v); chk("R5 edge rw", v, 32'h8);
        irq_in = 32'h8; settle(5);
        irq_in = '0;    settle(5);
        rd(8'h40, v); chk("R7 rise held", v, 32'h8);
        chk("R7 rise out", 32'(irq_out), 32'(obit(3)));
        wr(1'b1, 8'h40, 32'h4);
        settle(3);
        rd(8'h40, v); chk("R7 zero bit no clear", v, 32'h8);
        wr(1'b1, 8'h40, 32'h8);
        settle(3);
        rd(8'h40, v); chk("R7 cleared", v, 0);
        chk("R7 cleared out", 32'(irq_out), 0);
        // R7: falling edge on source 3
        wr(1'b1, 8'h30, 32'hFFFF_FFF7);
        settle(5);
        rd(8'h40, v); chk("R7 fall idle", v, 0);
        irq_in = 32'h8; settle(5);
        rd(8'h40, v); chk("R7 rise ignored in fall mode", v, 0);
        irq_in = '0; settle(5);
        rd(8'h40, v); chk("R7 fall captured", v, 32'h8);
        wr(1'b1, 8'h40, 32'h8);
        wr(1'b1, 8'h30, 32'hFFFF_FFFF);
        wr(1'b1, 8'h34, 32'h0);
        settle(5);

        // R9: zero route drives nothing; shared output ORs
        wr(1'b0, 8'h00, 32'h0);
        irq_in = 32'h1;
        settle(5);
        rd(8'h40, v); chk("R9 zero route status", v, 32'h1);
        chk("R9 zero route out", 32'(irq_out), 0);
        wr(1'b0, 8'h00, {24'h0, rbyte(0)});
        irq_in = 32'h0001_0001;
        settle(5);
        chk("R9 shared line", 32'(irq_out), 32'(obit(0) | obit(16)));
        irq_in = 32'h0001_0010;
        settle(5);
        chk("R9 two lines", 32'(irq_out), 32'(obit(4) | obit(16)));

        // R4: clear-all in one access
        wr(1'b1, 8'h2C, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R4 clear all", v, 0);
        irq_in = 32'hFFFF_FFFF;
        settle(5);
        rd(8'h40, v); chk("R4 all masked status", v, 0);
        chk("R4 all masked out", 32'(irq_out), 0);

        // R10: unmapped accesses
        wr(1'b1, 8'h38, 32'hFFFF_FFFF);
        wr(1'b1, 8'h20, 32'hFFFF_FFFF);
        wr(1'b0, 8'h28, 32'hFF);
        wr(1'b0, 8'h30, 32'h00);
        rd(8'h24, v); chk("R10 enable untouched", v, 0);
        rd(8'h30, v); chk("R10 polarity untouched", v, 32'hFFFF_FFFF);
        rd(8'h38, v); chk("R10 hole 38", v, 0);
        rd(8'h20, v); chk("R10 hole 20", v, 0);
        rd(8'h28, v); chk("R10 set reads zero", v, 0);
        rd(8'h2C, v); chk("R10 clr reads zero", v, 0);
        settle(3);
        chk("R10 out quiet", 32'(irq_out), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule